// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the per-vector message table and the pending-bit array of one PCI function. It also turns interrupt requests into message writes. Software reaches three spaces through a simple register port: the function control word, the vector table and the pending array. Each access carries an offset, a size (dword or qword) and write data. Read data is combinational from the current state.

A device raises an interrupt by pulsing `irq_valid` with a vector index. If the vector can send, the block places that entry's 64-bit address and 32-bit data on a valid/ready message output. If the vector cannot send, the block records the request in the pending array. A vector cannot send when its own mask is set, the function mask is set, or the function enable is clear. Pending vectors that become eligible are sent one per handshake, lowest index first, and their pending bits are cleared.

Top module: `msix_vector_ctrl`

## Requirements
- R1: After reset, the control word reads enable 0, function mask 0 and NUM_VEC-1 in bits 10:0. Every vector control dword reads 1 (masked), the pending array reads zero and `msg_valid` is low.
- R2: `reg_space` selects 0 = control word, 1 = vector table, 2 = pending array; 3 reads zero. Entry e sits at table offset 16e. Its dwords are address low at 0x0, address high at 0x4, data at 0x8 and vector control at 0xC. Only bit 0 of vector control is stored (the mask); its other bits read zero. A qword at 0x0 is {high, low} and a qword at 0x8 is {control, data}.
- R3: A table access that is not an aligned dword, or an aligned qword at entry offset 0x0 or 0x8, reads zero and changes nothing.
- R4: In the control word (offset 0), bit 15 (enable) and bit 14 (function mask) are writable. The other bits are read-only.
- R5: Vector v is pending bit v%64 of pending qword v/64. A dword read at 0x0 returns the low half and at 0x4 the high half. Writes to the pending array have no effect.
- R6: A request for a vector that is unmasked, with the function mask clear and enable set, shows up on the message output in the next cycle, carrying that entry's address and data.
- R7: A request for a masked vector sets its pending bit and sends nothing. Clearing that vector's mask, with the function mask clear, sends the message and clears the pending bit.
- R8: While the function mask is set, requests only set pending bits. When the function mask is cleared, every unmasked pending vector is sent, in ascending vector order.
- R9: Repeated requests for a vector whose pending bit is already set yield a single message.
- R10: A message held with `msg_ready` low keeps `msg_valid`, address and data unchanged until it is accepted.
- R11: A pending vector whose entry address is zero is dropped: no message is sent, and its pending bit is cleared.
- R12: While enable is clear, no message is sent and requests are recorded as pending. They are sent once enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | Access is a write |
| reg_space | input | 2 | 0 control, 1 table, 2 pending, 3 none |
| reg_off | input | OFF_W | Byte offset within the space |
| reg_qword | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reg_wdata | input | 64 | Write data (dword in bits 31:0) |
| reg_rdata | output | 64 | Read data for the addressed location |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | IDX_W | Requested vector index |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench attacks the unmask transitions. It covers an entry unmasked while pending, and a function-mask release with several vectors pending at once. A design that missed the edge would strand the pending bit, and one that scanned in the wrong order would send the vectors out of order. It also sends repeated requests for a vector that is already pending, which a counting design would turn into duplicate messages. A zero-address entry is left pending, which a careless design would either send or leave set forever. Misaligned table offsets and pending-array writes are checked for corrupting state, a stalled output for changing under backpressure, and a cleared enable for leaking messages.

// File: rtl/msix_pkg.sv
// Shared types for the MSI-X vector table controller.
// Assumes nothing beyond the IEEE 1800-2017 language.
package msix_pkg;
    typedef enum logic [1:0] {
        SP_CTRL  = 2'd0,
        SP_TABLE = 2'd1,
        SP_PEND  = 2'd2,
        SP_NONE  = 2'd3
    } space_e;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msg_t;
endpackage

// File: rtl/msix_entry_table.sv
// Vector table storage: per-entry address, data and mask bit.
// Decodes aligned dword/qword accesses. Other sizes or offsets read zero
// and are not written. Entries reset masked. Assumes NUM_VEC >= 2.
module msix_entry_table
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int OFF_W   = 7,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [OFF_W-1:0]   off,
    input  logic               qword,
    input  logic [63:0]        wdata,
    output logic [63:0]        rdata,
    output logic [NUM_VEC-1:0] mask_vec,
    input  logic [IDX_W-1:0]   lk_idx,
    output msg_t               lk_msg
);
    localparam int ENT_W = OFF_W - 4;

    logic [31:0] lo_q  [NUM_VEC];
    logic [31:0] hi_q  [NUM_VEC];
    logic [31:0] dat_q [NUM_VEC];
    logic [NUM_VEC-1:0] mask_q;

    logic [ENT_W-1:0] ent_full;
    logic [IDX_W-1:0] ent;
    logic ent_ok, dw_ok, qw_ok;
    logic w_lo, w_hi, w_dat, w_ctl;
    logic [31:0] v_lo, v_hi, v_dat;
    logic v_ctl;

    // Decode which fields the access covers and their new values
    always_comb begin
        ent_full = off[OFF_W-1:4];
        ent      = ent_full[IDX_W-1:0];
        ent_ok   = int'(ent_full) < NUM_VEC;
        dw_ok    = ent_ok && !qword && (off[1:0] == 2'b00);
        qw_ok    = ent_ok && qword && (off[2:0] == 3'b000);
        w_lo = 1'b0; w_hi = 1'b0; w_dat = 1'b0; w_ctl = 1'b0;
        v_lo = wdata[31:0]; v_hi = wdata[31:0]; v_dat = wdata[31:0]; v_ctl = wdata[0];
        if (dw_ok) begin
            case (off[3:2])
                2'd0:    w_lo  = 1'b1;
                2'd1:    w_hi  = 1'b1;
                2'd2:    w_dat = 1'b1;
                default: w_ctl = 1'b1;
            endcase
        end else if (qw_ok) begin
            if (!off[3]) begin
                w_lo = 1'b1; w_hi = 1'b1; v_hi = wdata[63:32];
            end else begin
                w_dat = 1'b1; w_ctl = 1'b1; v_ctl = wdata[32];
            end
        end
    end

    // Store entry fields; masks reset set
    always_ff @(posedge clk) begin
        for (int e = 0; e < NUM_VEC; e++) begin
            if (!rst_n) begin
                lo_q[e]   <= '0;
                hi_q[e]   <= '0;
                dat_q[e]  <= '0;
                mask_q[e] <= 1'b1;
            end else if (wr_en && ent == IDX_W'(e)) begin
                if (w_lo)  lo_q[e]   <= v_lo;
                if (w_hi)  hi_q[e]   <= v_hi;
                if (w_dat) dat_q[e]  <= v_dat;
                if (w_ctl) mask_q[e] <= v_ctl;
            end
        end
    end

    // Return the addressed field, zero for illegal accesses
    always_comb begin
        rdata = '0;
        if (dw_ok) begin
            case (off[3:2])
                2'd0:    rdata = {32'd0, lo_q[ent]};
                2'd1:    rdata = {32'd0, hi_q[ent]};
                2'd2:    rdata = {32'd0, dat_q[ent]};
                default: rdata = {63'd0, mask_q[ent]};
            endcase
        end else if (qw_ok) begin
            rdata = off[3] ? {31'd0, mask_q[ent], dat_q[ent]} : {hi_q[ent], lo_q[ent]};
        end
    end

    // Lookup port for the message engine
    always_comb begin
        lk_msg.addr = {hi_q[lk_idx], lo_q[lk_idx]};
        lk_msg.data = dat_q[lk_idx];
    end

    assign mask_vec = mask_q;
endmodule

// File: rtl/msix_pending_array.sv
// Pending-bit array: one bit per vector, packed 64 per qword, read-only to software.
// Set and clear ports come from the message engine; clear wins on the same vector,
// because a request that meets its own dispatch merges into that message.
module msix_pending_array #(
    parameter int NUM_VEC = 8,
    parameter int OFF_W   = 7,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic [OFF_W-1:0]   off,
    input  logic               qword,
    output logic [63:0]        rdata,
    output logic [NUM_VEC-1:0] pend_vec
);
    localparam int PBA_QW = (NUM_VEC + 63) / 64;
    localparam int PQ_W   = OFF_W - 3;

    logic [NUM_VEC-1:0]    pend_q;
    logic [PBA_QW*64-1:0]  pend_pad;
    logic [63:0]           qsel;
    logic [PQ_W-1:0]       pq;

    // Update pending bits; clear overrides set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (clr_en && clr_idx == IDX_W'(v))      pend_q[v] <= 1'b0;
                else if (set_en && set_idx == IDX_W'(v)) pend_q[v] <= 1'b1;
            end
        end
    end

    // Select the addressed qword and half
    always_comb begin
        pend_pad = '0;
        pend_pad[NUM_VEC-1:0] = pend_q;
        pq   = off[OFF_W-1:3];
        qsel = '0;
        for (int q = 0; q < PBA_QW; q++)
            if (int'(pq) == q) qsel = pend_pad[q*64 +: 64];
        rdata = '0;
        if (qword) begin
            if (off[2:0] == 3'b000) rdata = qsel;
        end else if (off[2:0] == 3'b000) begin
            rdata = {32'd0, qsel[31:0]};
        end else if (off[2:0] == 3'b100) begin
            rdata = {32'd0, qsel[63:32]};
        end
    end

    assign pend_vec = pend_q;
endmodule

// File: rtl/msix_dispatch.sv
// Message engine: sends eligible requests directly, or else records them as pending.
// Replays eligible pending vectors lowest index first, one per free output slot.
// Drops entries whose address is zero. Assumes table and pending state are registered.
module msix_dispatch
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               fmask,
    input  logic               irq_valid,
    input  logic [IDX_W-1:0]   irq_vec,
    input  logic [NUM_VEC-1:0] mask_vec,
    input  logic [NUM_VEC-1:0] pend_vec,
    output logic [IDX_W-1:0]   lk_idx,
    input  msg_t               lk_msg,
    output logic               set_en,
    output logic [IDX_W-1:0]   set_idx,
    output logic               clr_en,
    output logic [IDX_W-1:0]   clr_idx,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    logic [NUM_VEC-1:0] elig;
    logic [IDX_W-1:0]   pick;
    logic any_elig, slot_free, req_ok, direct, load;

    // Choose between replay and direct send for this cycle
    always_comb begin
        elig     = pend_vec & ~mask_vec;
        any_elig = enable && !fmask && (|elig);
        pick     = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--)
            if (elig[v]) pick = IDX_W'(v);
        slot_free = !msg_valid || msg_ready;
        req_ok    = irq_valid && (int'(irq_vec) < NUM_VEC);
        direct    = req_ok && enable && !fmask && !mask_vec[irq_vec]
                    && !pend_vec[irq_vec] && !any_elig && slot_free;
        lk_idx  = any_elig ? pick : irq_vec;
        clr_en  = any_elig && slot_free;
        clr_idx = pick;
        set_en  = req_ok && !direct;
        set_idx = irq_vec;
        load    = (clr_en || direct) && (lk_msg.addr != 64'd0);
    end

    // Output message register under valid/ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_addr  <= lk_msg.addr;
            msg_data  <= lk_msg.data;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/msix_vector_ctrl.sv
// Top of the MSI-X vector table controller: register port decode, function
// control bits, table, pending array and message engine.
// Assumes 2 <= NUM_VEC <= 2048 and a single clock domain.
module msix_vector_ctrl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int OFF_W  = $clog2(NUM_VEC * 16),
    localparam int IDX_W  = $clog2(NUM_VEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_en,
    input  logic             reg_wr,
    input  logic [1:0]       reg_space,
    input  logic [OFF_W-1:0] reg_off,
    input  logic             reg_qword,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    input  logic             irq_valid,
    input  logic [IDX_W-1:0] irq_vec,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [63:0]      msg_addr,
    output logic [31:0]      msg_data
);
    space_e             sp;
    logic               ctl_enable, ctl_fmask;
    logic               ctl_hit;
    logic [NUM_VEC-1:0] vmask, pend_bits;
    logic [63:0]        tbl_rdata, pnd_rdata;
    logic [IDX_W-1:0]   lk_idx, set_idx, clr_idx;
    logic               set_en, clr_en;
    msg_t               lk_msg;

    assign sp      = space_e'(reg_space);
    assign ctl_hit = (sp == SP_CTRL) && (reg_off == '0);

    // Function enable and function mask control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_enable <= 1'b0;
            ctl_fmask  <= 1'b0;
        end else if (reg_en && reg_wr && ctl_hit) begin
            ctl_enable <= reg_wdata[15];
            ctl_fmask  <= reg_wdata[14];
        end
    end

    msix_entry_table #(.NUM_VEC(NUM_VEC), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_en && reg_wr && sp == SP_TABLE),
        .off      (reg_off),
        .qword    (reg_qword),
        .wdata    (reg_wdata),
        .rdata    (tbl_rdata),
        .mask_vec (vmask),
        .lk_idx   (lk_idx),
        .lk_msg   (lk_msg)
    );

    msix_pending_array #(.NUM_VEC(NUM_VEC), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .set_idx  (set_idx),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .off      (reg_off),
        .qword    (reg_qword),
        .rdata    (pnd_rdata),
        .pend_vec (pend_bits)
    );

    msix_dispatch #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (ctl_enable),
        .fmask     (ctl_fmask),
        .irq_valid (irq_valid),
        .irq_vec   (irq_vec),
        .mask_vec  (vmask),
        .pend_vec  (pend_bits),
        .lk_idx    (lk_idx),
        .lk_msg    (lk_msg),
        .set_en    (set_en),
        .set_idx   (set_idx),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    // Read mux across the three spaces
    always_comb begin
        case (sp)
            SP_CTRL:  reg_rdata = ctl_hit ? {48'd0, ctl_enable, ctl_fmask, 3'd0, 11'(NUM_VEC - 1)} : 64'd0;
            SP_TABLE: reg_rdata = tbl_rdata;
            SP_PEND:  reg_rdata = pnd_rdata;
            default:  reg_rdata = 64'd0;
        endcase
    end
endmodule

// File: rtl/msix_vector_ctrl_chk.sv
// Protocol checker for msix_vector_ctrl, attached by bind.
// Observes the ports plus the control bits, mask and pending vectors.
module msix_vector_ctrl_chk #(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_valid,
    input logic [IDX_W-1:0]   irq_vec,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic               ctl_enable,
    input logic               ctl_fmask,
    input logic [NUM_VEC-1:0] mask_vec,
    input logic [NUM_VEC-1:0] pend_vec
);
    // R10: a stalled message holds its contents
    assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R12: nothing new is loaded while enable is clear
    assert_quiet_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_enable && (!msg_valid || msg_ready)) |=> !msg_valid);

    // R8: nothing new is loaded while the function mask is set
    assert_quiet_fmask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_fmask && (!msg_valid || msg_ready)) |=> !msg_valid);

    // R7: a request to a masked vector lands in the pending array
    assert_masked_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && (int'(irq_vec) < NUM_VEC) && mask_vec[irq_vec]) |=> pend_vec[$past(irq_vec)]);

    // R11: no message is ever sent to address zero
    assert_no_zero_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr != 64'd0));
endmodule

bind msix_vector_ctrl msix_vector_ctrl_chk #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_valid  (irq_valid),
    .irq_vec    (irq_vec),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data),
    .ctl_enable (ctl_enable),
    .ctl_fmask  (ctl_fmask),
    .mask_vec   (vmask),
    .pend_vec   (pend_bits)
);

// File: tb/msix_vector_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for msix_vector_ctrl: one task per scenario, each checks its own results.
module msix_vector_ctrl_test;
    localparam int N    = 8;
    localparam int OFFW = 7;
    localparam int IDXW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_en = 1'b0, reg_wr = 1'b0, reg_qword = 1'b0;
    logic [1:0] reg_space = 2'd0;
    logic [OFFW-1:0] reg_off = '0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic irq_valid = 1'b0;
    logic [IDXW-1:0] irq_vec = '0;
    logic msg_valid, msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int checks = 0, errors = 0, mcnt = 0;
    bit done = 0;
    logic [63:0] got_addr [64];
    logic [31:0] got_data [64];

    always #2.5 clk = ~clk;

    msix_vector_ctrl #(.NUM_VEC(N)) uut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_space(reg_space), .reg_off(reg_off), .reg_qword(reg_qword),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // Record every accepted message
    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready && mcnt < 64) begin
            got_addr[mcnt] = msg_addr;
            got_data[mcnt] = msg_data;
            mcnt++;
        end
    end

    function automatic logic [63:0] exp_addr(int e);
        if (e == 7) return 64'd0;
        return {32'hA0 + 32'(e), 32'hFEE0_0000 + 32'(e * 16)};
    endfunction
    function automatic logic [31:0] exp_data(int e);
        return 32'hD000 + 32'(e);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] sp, int off, logic qw, logic [63:0] d);
        @(negedge clk);
        reg_en = 1; reg_wr = 1; reg_space = sp; reg_off = OFFW'(off); reg_qword = qw; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_wr = 0;
    endtask

    task automatic reg_read(logic [1:0] sp, int off, logic qw, output logic [63:0] d);
        @(negedge clk);
        reg_en = 1; reg_wr = 0; reg_space = sp; reg_off = OFFW'(off); reg_qword = qw;
        #1 d = reg_rdata;
        reg_en = 0;
    endtask

    task automatic raise(int v);
        @(negedge clk);
        irq_valid = 1; irq_vec = IDXW'(v);
        @(negedge clk);
        irq_valid = 0;
    endtask

    task automatic t_reset;
        logic [63:0] d;
        check("R1 msg_valid", {63'd0, msg_valid}, 64'd0);
        reg_read(2'd0, 0, 0, d); check("R1 control word", d, 64'h0007);
        reg_read(2'd1, 3*16 + 12, 0, d); check("R1 entry3 mask", d, 64'd1);
        reg_read(2'd2, 0, 1, d); check("R1 pending", d, 64'd0);
    endtask

    task automatic t_table_access;
        logic [63:0] d;
        reg_write(2'd1, 0, 0, 64'h1111_2222);
        reg_write(2'd1, 4, 0, 64'h3333_4444);
        reg_write(2'd1, 8, 0, 64'h5555_6666);
        reg_read(2'd1, 0, 1, d); check("R2 qword addr", d, 64'h3333_4444_1111_2222);
        reg_read(2'd1, 4, 0, d); check("R2 dword addr high", d, 64'h3333_4444);
        reg_write(2'd1, 8, 1, 64'h0000_0000_7777_8888);
        reg_read(2'd1, 8, 1, d); check("R2 qword ctrl:data", d, 64'h0000_0000_7777_8888);
        reg_write(2'd1, 12, 0, 64'hFFFF_FFFF);
        reg_read(2'd1, 12, 0, d); check("R2 only mask bit kept", d, 64'd1);
        reg_write(2'd1, 2, 0, 64'hDEAD_BEEF);
        reg_read(2'd1, 0, 0, d); check("R3 misaligned write ignored", d, 64'h1111_2222);
        reg_read(2'd1, 2, 0, d); check("R3 misaligned read zero", d, 64'd0);
        reg_read(2'd1, 4, 1, d); check("R3 qword at 0x4 zero", d, 64'd0);
        reg_read(2'd3, 0, 0, d); check("R2 unused space zero", d, 64'd0);
    endtask

    task automatic t_control;
        logic [63:0] d;
        reg_write(2'd0, 0, 0, 64'hFFFF);
        reg_read(2'd0, 0, 0, d); check("R4 control writable bits", d, 64'hC007);
        reg_write(2'd0, 0, 0, 64'h0000);
        reg_read(2'd0, 0, 0, d); check("R4 control cleared", d, 64'h0007);
    endtask

    task automatic t_pending_ro;
        logic [63:0] d;
        reg_write(2'd2, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_read(2'd2, 0, 1, d); check("R5 pending write ignored", d, 64'd0);
    endtask

    task automatic setup_entries;
        for (int e = 0; e < N; e++) begin
            reg_write(2'd1, e*16, 1, exp_addr(e));
            reg_write(2'd1, e*16 + 8, 0, {32'd0, exp_data(e)});
        end
        reg_write(2'd1, 1*16 + 12, 0, 64'd0);
        reg_write(2'd1, 2*16 + 12, 0, 64'd0);
        reg_write(2'd1, 5*16 + 12, 0, 64'd0);
        reg_write(2'd1, 6*16 + 12, 0, 64'd0);
        reg_write(2'd1, 7*16 + 12, 0, 64'd0);
        reg_write(2'd0, 0, 0, 64'h8000);
    endtask

    task automatic t_direct;
        int base = mcnt;
        raise(1);
        check("R6 valid next cycle", {63'd0, msg_valid}, 64'd1);
        check("R6 address", msg_addr, exp_addr(1));
        repeat (3) @(negedge clk);
        check("R6 one message", 64'(mcnt - base), 64'd1);
        check("R6 data", {32'd0, got_data[base]}, {32'd0, exp_data(1)});
    endtask

    task automatic t_masked;
        logic [63:0] d;
        int base = mcnt;
        raise(4);
        repeat (3) @(negedge clk);
        check("R7 masked sends nothing", 64'(mcnt - base), 64'd0);
        reg_read(2'd2, 0, 0, d); check("R7 pending bit 4", d, 64'h10);
        reg_write(2'd1, 4*16 + 12, 0, 64'd0);
        repeat (4) @(negedge clk);
        check("R7 unmask replays", 64'(mcnt - base), 64'd1);
        check("R7 replay address", got_addr[base], exp_addr(4));
        reg_read(2'd2, 0, 0, d); check("R7 pending cleared", d, 64'd0);
    endtask

    task automatic t_fmask;
        logic [63:0] d;
        int base = mcnt;
        reg_write(2'd0, 0, 0, 64'hC000);
        raise(5); raise(5); raise(2); raise(6);
        repeat (3) @(negedge clk);
        check("R8 nothing under function mask", 64'(mcnt - base), 64'd0);
        reg_read(2'd2, 4, 0, d); check("R5 high half", d, 64'd0);
        reg_read(2'd2, 0, 0, d); check("R8 pending 2,5,6", d, 64'h64);
        reg_write(2'd0, 0, 0, 64'h8000);
        repeat (10) @(negedge clk);
        check("R9 one message per pending bit", 64'(mcnt - base), 64'd3);
        check("R8 order first", got_addr[base], exp_addr(2));
        check("R8 order second", got_addr[base+1], exp_addr(5));
        check("R8 order third", got_addr[base+2], exp_addr(6));
        reg_read(2'd2, 0, 0, d); check("R8 pending cleared", d, 64'd0);
    endtask

    task automatic t_zero_addr;
        logic [63:0] d;
        int base = mcnt;
        reg_write(2'd0, 0, 0, 64'hC000);
        raise(7);
        reg_read(2'd2, 0, 0, d); check("R11 pending bit 7", d, 64'h80);
        reg_write(2'd0, 0, 0, 64'h8000);
        repeat (5) @(negedge clk);
        check("R11 zero address dropped", 64'(mcnt - base), 64'd0);
        reg_read(2'd2, 0, 0, d); check("R11 pending cleared", d, 64'd0);
    endtask

    task automatic t_backpressure;
        int base = mcnt;
        @(negedge clk); msg_ready = 0;
        raise(1);
        repeat (3) @(negedge clk);
        check("R10 valid held", {63'd0, msg_valid}, 64'd1);
        check("R10 address held", msg_addr, exp_addr(1));
        check("R10 data held", {32'd0, msg_data}, {32'd0, exp_data(1)});
        msg_ready = 1;
        repeat (2) @(negedge clk);
        check("R10 accepted once", 64'(mcnt - base), 64'd1);
        check("R10 valid dropped", {63'd0, msg_valid}, 64'd0);
    endtask

    task automatic t_disable;
        logic [63:0] d;
        int base = mcnt;
        reg_write(2'd0, 0, 0, 64'h0000);
        raise(1);
        repeat (4) @(negedge clk);
        check("R12 disabled sends nothing", 64'(mcnt - base), 64'd0);
        reg_read(2'd2, 0, 0, d); check("R12 request pending", d, 64'h02);
        reg_write(2'd0, 0, 0, 64'h8000);
        repeat (4) @(negedge clk);
        check("R12 sent after enable", 64'(mcnt - base), 64'd1);
        check("R12 address", got_addr[base], exp_addr(1));
        reg_read(2'd2, 0, 0, d); check("R12 pending cleared", d, 64'd0);
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_table_access;
        t_control;
        t_pending_ro;
        setup_entries;
        t_direct;
        t_masked;
        t_fmask;
        t_zero_addr;
        t_backpressure;
        t_disable;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule